// File: doc/BRIEF.md
# Lead/Lag Compensator with Serial Fixed-Point Arithmetic

This block applies a first-order lead/lag correction to a stream of signed samples, one sample per computation run. For every accepted sample it forms the next output from the new sample, the previous sample and the previous output. It uses three constants: a gain, a lead pole term and a lag pole term. All arithmetic is integer. Fractions are held as numerators with a fixed power-of-two denominator, and every product is rounded back to integer scale with an arithmetic right shift.

Products are formed bit-serially. One operand sits in a register and the coefficient is consumed one bit per clock, least significant bit first. Its top bit carries negative weight. The lead and lag products run side by side. A parallel subtract then removes the weighted previous sample, and a third serial multiply applies the gain. Each run takes a fixed number of clocks, which keeps the output rate independent of the data. The three constants come from a configuration register file on plain pins and must be held steady while a run is in progress.

Samples enter on a valid/ready handshake. Ready is high only when the block is idle. It drops at the accepting edge and stays low through the run and for as long as the result waits to be taken. A finished result is offered with a held valid. While the consumer keeps ready low, the result stays unchanged and no new sample is taken, so back-pressure reaches the input side directly.

Top module: `lead_lag_filter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the stored previous sample and previous output to zero, makes in_ready 1 and out_valid 0.
- R2: A sample is taken at a rising edge where in_valid and in_ready are both 1. in_ready is 0 from that edge until the edge where the result is taken with out_ready.
- R3: out_valid becomes 1 exactly 64 clock edges after the accepting edge.
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_sample does not change.
- R5: in_sample is 12-bit two's complement. cfg_lead (A) and cfg_lag (B) are 18-bit two's complement with 16 fraction bits, and cfg_gain (G) is 24-bit two's complement with 8 fraction bits. With previous sample xp and previous output yp, the block first forms D = x·2^16 − A·xp and then y = sat(rnd(G·D, 24) + rnd(B·yp, 16)).
- R6: rnd(v, s) rounds half up: floor((v + 2^(s−1)) / 2^s). So +0.5 goes to 1 and −0.5 goes to 0.
- R7: sat limits the sum to the 24-bit signed range [−8388608, 8388607] instead of wrapping.
- R8: When a run ends, the sample becomes the new previous sample and the saturated result becomes the new previous output.
- R9: Negative samples and negative coefficients follow the same formula through two's complement arithmetic.
- R10: in_valid and in_sample have no effect while in_ready is 0. The result and the next run depend only on the sample taken at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_gain | input | 24 | Gain product G, two's complement, 8 fraction bits |
| cfg_lead | input | 18 | Lead term A, two's complement, 16 fraction bits |
| cfg_lag | input | 18 | Lag term B, two's complement, 16 fraction bits |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block idle and able to take a sample |
| in_sample | input | 12 | Input sample, two's complement |
| out_valid | output | 1 | Result available, held until taken |
| out_ready | input | 1 | Consumer takes the result |
| out_sample | output | 24 | Result, two's complement |

## Verification
The bench starts with a sample taken straight from reset, where both history terms are zero. This isolates the gain path from the lead and lag paths. A multi-sample sequence with realistic pole terms then exercises the carried history: a wrong update of the previous sample or previous output shows up only from the second sample on. Negative samples and a negative gain separate correct signed handling from magnitude-only arithmetic. Exact half-way values separate round-half-up from truncation and from floor. Full-scale inputs at maximum gain separate saturation from wraparound, and the run that follows shows whether the clamped value was stored. A long output stall checks that the result is held. Keeping in_valid high with changing data during a run checks that nothing is taken while busy.

// File: rtl/llf_pkg.sv
package llf_pkg;

  // Sequencer states: waiting for a sample, computing, holding a result.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } llf_state_e;

endpackage

// File: rtl/llf_serial_mul.sv
// Parallel-serial multiplier: operand a is held in parallel, operand b is
// consumed one bit per clock LSB first. Result is valid BW clocks after start.
module llf_serial_mul #(
  parameter int AW      = 12,
  parameter int BW      = 18,
  parameter bit BSIGNED = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic signed [AW-1:0]        a,
  input  logic        [BW-1:0]        b,
  output logic signed [AW+BW-1:0]     prod
);
  localparam int RW = AW + BW;
  localparam int IW = $clog2(BW + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(BW - 1);

  logic signed [RW-1:0] acc;
  logic signed [RW-1:0] mcand;
  logic        [BW-1:0] mplier;
  logic        [IW-1:0] idx;
  logic                 run;
  logic                 last;
  logic                 neg_step;

  assign last = (idx == LAST_IDX);

  // The top serial bit carries negative weight only for a signed operand.
  generate
    if (BSIGNED) begin : g_signed
      assign neg_step = last;
    end else begin : g_unsigned
      assign neg_step = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      idx    <= '0;
      run    <= 1'b0;
    end else if (start) begin
      acc    <= '0;
      mcand  <= RW'(a);
      mplier <= b;
      idx    <= '0;
      run    <= 1'b1;
    end else if (run) begin
      if (mplier[0]) begin
        acc <= neg_step ? (acc - mcand) : (acc + mcand);
      end
      mcand  <= mcand <<< 1;
      mplier <= mplier >> 1;
      idx    <= idx + 1'b1;
      if (last) begin
        run <= 1'b0;
      end
    end
  end

  assign prod = acc;
endmodule

// File: rtl/llf_seq.sv
// Run sequencer: handshake state and fixed-offset strobes within a run.
module llf_seq
  import llf_pkg::*;
#(
  parameter int LAT = 64,
  parameter int CW  = 18,
  parameter int GW  = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic accept,
  output logic sub_en,
  output logic gain_start,
  output logic fin_en
);
  localparam int CNW = $clog2(LAT);
  // First-stage products settle CW clocks after acceptance; the gain
  // product settles GW clocks after its load edge.
  localparam logic [CNW-1:0] C_SUB  = CNW'(CW);
  localparam logic [CNW-1:0] C_GST  = CNW'(CW + 1);
  localparam logic [CNW-1:0] C_FIN  = CNW'(CW + 2 + GW);
  localparam logic [CNW-1:0] C_LAST = CNW'(LAT - 1);

  llf_state_e       state;
  logic [CNW-1:0]   cnt;
  logic             running;

  assign running    = (state == ST_RUN);
  assign in_ready   = (state == ST_IDLE);
  assign out_valid  = (state == ST_HOLD);
  assign accept     = in_ready && in_valid;
  assign sub_en     = running && (cnt == C_SUB);
  assign gain_start = running && (cnt == C_GST);
  assign fin_en     = running && (cnt == C_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (in_valid) state <= ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == C_LAST) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/llf_post.sv
// Rounds both products half up, adds them and clamps to the output width.
module llf_post #(
  parameter int PGW = 56,
  parameter int PBW = 42,
  parameter int GSH = 24,
  parameter int BSH = 16,
  parameter int DW  = 24
) (
  input  logic signed [PGW-1:0] pg,
  input  logic signed [PBW-1:0] pb,
  output logic signed [DW-1:0]  y
);
  localparam int SW = PGW + 1;
  localparam logic signed [PGW-1:0] HALF_G = PGW'(1) << (GSH - 1);
  localparam logic signed [PBW-1:0] HALF_B = PBW'(1) << (BSH - 1);
  localparam logic signed [SW-1:0]  MAXV   = (SW'(1) << (DW - 1)) - SW'(1);
  localparam logic signed [SW-1:0]  MINV   = ~MAXV;

  logic signed [PGW-1:0] t_gain;
  logic signed [PBW-1:0] t_lag;
  logic signed [SW-1:0]  sum;

  always_comb begin
    t_gain = (pg + HALF_G) >>> GSH;
    t_lag  = (pb + HALF_B) >>> BSH;
    sum    = SW'(t_gain) + SW'(t_lag);
    if (sum > MAXV) begin
      y = MAXV[DW-1:0];
    end else if (sum < MINV) begin
      y = MINV[DW-1:0];
    end else begin
      y = sum[DW-1:0];
    end
  end
endmodule

// File: rtl/lead_lag_filter.sv
module lead_lag_filter #(
  parameter int XW  = 12,
  parameter int DW  = 24,
  parameter int CW  = 18,
  parameter int CFB = 16,
  parameter int GW  = 24,
  parameter int GFB = 8,
  parameter int PW  = 32,
  parameter int LAT = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic        [GW-1:0] cfg_gain,
  input  logic        [CW-1:0] cfg_lead,
  input  logic        [CW-1:0] cfg_lag,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [XW-1:0] in_sample,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_sample
);
  localparam int PAW = XW + CW;
  localparam int PBW = DW + CW;
  localparam int PGW = PW + GW;

  logic accept, sub_en, gain_start, fin_en;

  logic signed [XW-1:0]  x_cur;
  logic signed [XW-1:0]  x_prev;
  logic signed [DW-1:0]  y_prev;
  logic signed [PW-1:0]  d_reg;
  logic signed [PAW-1:0] p_lead;
  logic signed [PBW-1:0] p_lag;
  logic signed [PGW-1:0] p_gain;
  logic signed [DW-1:0]  y_new;

  llf_seq #(.LAT(LAT), .CW(CW), .GW(GW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .accept     (accept),
    .sub_en     (sub_en),
    .gain_start (gain_start),
    .fin_en     (fin_en)
  );

  // Lead term A * x(n-1) and lag term B * y(n-1) run side by side.
  llf_serial_mul #(.AW(XW), .BW(CW), .BSIGNED(1'b1)) u_mul_lead (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .a     (x_prev),
    .b     (cfg_lead),
    .prod  (p_lead)
  );

  llf_serial_mul #(.AW(DW), .BW(CW), .BSIGNED(1'b1)) u_mul_lag (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .a     (y_prev),
    .b     (cfg_lag),
    .prod  (p_lag)
  );

  // Gain applied to the difference held in a PW-bit parallel register.
  llf_serial_mul #(.AW(PW), .BW(GW), .BSIGNED(1'b1)) u_mul_gain (
    .clk   (clk),
    .rst   (rst),
    .start (gain_start),
    .a     (d_reg),
    .b     (cfg_gain),
    .prod  (p_gain)
  );

  llf_post #(
    .PGW (PGW),
    .PBW (PBW),
    .GSH (GFB + CFB),
    .BSH (CFB),
    .DW  (DW)
  ) u_post (
    .pg (p_gain),
    .pb (p_lag),
    .y  (y_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_cur  <= '0;
      x_prev <= '0;
      y_prev <= '0;
      d_reg  <= '0;
    end else begin
      if (accept) begin
        x_cur <= in_sample;
      end
      if (sub_en) begin
        // Parallel subtract: new sample at 2^CFB scale minus the lead term.
        d_reg <= (PW'(x_cur) <<< CFB) - PW'(p_lead);
      end
      if (fin_en) begin
        x_prev <= x_cur;
        y_prev <= y_new;
      end
    end
  end

  assign out_sample = y_prev;
endmodule

// File: rtl/llf_checker.sv
module llf_checker #(
  parameter int LAT = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_sample
);
  logic [15:0] since_acc;
  logic        tracking;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_acc <= '0;
      tracking  <= 1'b0;
    end else if (in_valid && in_ready) begin
      since_acc <= '0;
      tracking  <= 1'b1;
    end else if (tracking && !out_valid) begin
      since_acc <= since_acc + 1'b1;
    end else if (out_valid) begin
      tracking <= 1'b0;
    end
  end

  // R1: reset leaves the block idle with no result offered
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid));

  // R2: acceptance closes the input side
  a_r2_accept_closes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R2: no sample is taken while a result is offered
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R3: result appears a fixed number of edges after acceptance
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (tracking && since_acc == 16'(LAT)));

  // R4: a stalled result is held unchanged
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));
endmodule

bind lead_lag_filter llf_checker #(.LAT(LAT)) u_llf_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample)
);

// File: tb/lead_lag_filter_tb.sv
`timescale 1ns/1ps
module lead_lag_filter_tb;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic        [23:0] cfg_gain = '0;
  logic        [17:0] cfg_lead = '0;
  logic        [17:0] cfg_lag  = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [11:0] in_sample = '0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic signed [23:0] out_sample;

  int nchk = 0;
  int nerr = 0;
  longint mx1 = 0;
  longint my1 = 0;
  longint mg = 0, ma = 0, mb = 0;

  always #10 clk = ~clk;

  lead_lag_filter u_dut (
    .clk        (clk),
    .rst        (rst),
    .cfg_gain   (cfg_gain),
    .cfg_lead   (cfg_lead),
    .cfg_lag    (cfg_lag),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sample  (in_sample),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample)
  );

  task automatic chk(input longint act, input longint exp, input string what);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint rnd(input longint v, input int s);
    return (v + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

  // Reference from R5, R6, R7
  function automatic longint model(input longint x);
    longint d, s;
    d = x * 65536 - ma * mx1;
    s = rnd(mg * d, 24) + rnd(mb * my1, 16);
    if (s > 8388607) s = 8388607;
    if (s < -8388608) s = -8388608;
    return s;
  endfunction

  task automatic set_cfg(input longint g, input longint a, input longint b);
    @(negedge clk);
    mg = g; ma = a; mb = b;
    cfg_gain = 24'(g);
    cfg_lead = 18'(a);
    cfg_lag  = 18'(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mx1 = 0; my1 = 0;
  endtask

  // Sends one sample, checks latency, value, hold and release.
  task automatic run_sample(input longint x, input int stall, input bit junk, input string tag);
    longint exp;
    int n;
    logic signed [23:0] held;
    bit ready_leak;
    exp = model(x);
    @(negedge clk);
    chk(in_ready, 1, {"R2 ready when idle ", tag});
    in_sample = 12'(x);
    in_valid  = 1'b1;
    @(negedge clk);
    chk(in_ready, 0, {"R2 ready drops after accept ", tag});
    if (!junk) in_valid = 1'b0;
    n = 0;
    ready_leak = 1'b0;
    while (!out_valid && n < 200) begin
      if (junk) in_sample = ~in_sample;
      if (in_ready) ready_leak = 1'b1;
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    if (junk) chk(ready_leak, 0, {"R10 no ready while busy ", tag});
    chk(n, 64, {"R3 latency ", tag});
    chk(out_sample, exp, {"R5 result ", tag});
    held = out_sample;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(out_valid && (out_sample == held) && !in_ready, 1, {"R4 hold under stall ", tag});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid, 0, {"R2 result taken ", tag});
    chk(in_ready, 1, {"R2 ready after take ", tag});
    mx1 = x;
    my1 = exp;
  endtask

  task automatic t_reset();
    do_reset();
    chk(in_ready, 1, "R1 in_ready after reset");
    chk(out_valid, 0, "R1 out_valid after reset");
  endtask

  task automatic t_first();
    // Both history terms zero: only the gain path contributes (R1, R5)
    set_cfg(640, 62259, 64225);
    run_sample(100, 0, 0, "R1 first sample from zero history");
  endtask

  task automatic t_track();
    // Realistic pole terms, several samples: history carried (R5, R8)
    set_cfg(640, 62259, 64225);
    run_sample(500, 0, 0, "R8 step a");
    run_sample(500, 0, 0, "R8 step b");
    run_sample(500, 0, 0, "R8 step c");
    set_cfg(25600, 65470, 59245);
    run_sample(-300, 0, 0, "R8 step d");
    run_sample(1200, 0, 0, "R8 step e");
  endtask

  task automatic t_signed();
    // Negative samples and a negative gain (R9)
    do_reset();
    set_cfg(-384, 60000, 50000);
    run_sample(-2048, 0, 0, "R9 neg sample neg gain");
    run_sample(-7, 0, 0, "R9 second neg sample");
    set_cfg(1000, -20000, -30000);
    run_sample(333, 0, 0, "R9 neg lead and lag");
  endtask

  task automatic t_round();
    // G = 0.5, no history: +0.5 -> 1, then -1.5 -> -1, -0.5 -> 0 (R6)
    do_reset();
    set_cfg(128, 0, 0);
    run_sample(1, 0, 0, "R6 plus half");
    chk(my1, 1, "R6 plus half rounds up");
    run_sample(-3, 0, 0, "R6 minus one and half");
    chk(my1, -1, "R6 minus one and half rounds up");
    run_sample(-1, 0, 0, "R6 minus half");
    chk(my1, 0, "R6 minus half rounds to zero");
  endtask

  task automatic t_sat();
    // Full scale at maximum gain clamps; stored value is the clamp (R7, R8)
    do_reset();
    set_cfg(8388607, 0, 0);
    run_sample(2047, 0, 0, "R7 positive clamp");
    chk(my1, 8388607, "R7 positive limit");
    run_sample(-2048, 0, 0, "R7 negative clamp");
    chk(my1, -8388608, "R7 negative limit");
    set_cfg(0, 0, 32768);
    run_sample(0, 0, 0, "R8 clamped output stored");
    chk(my1, -4194304, "R8 half of stored clamp");
  endtask

  task automatic t_stall();
    set_cfg(700, 63000, 64000);
    run_sample(77, 9, 0, "R4 stall nine");
    run_sample(-900, 3, 0, "R4 stall three");
  endtask

  task automatic t_busy();
    // Changing data with in_valid high during a run is ignored (R10)
    set_cfg(700, 63000, 64000);
    run_sample(250, 2, 1, "R10 junk during run");
    run_sample(-40, 0, 0, "R10 next run uses accepted sample");
  endtask

  initial begin
    t_reset();
    t_first();
    t_track();
    t_signed();
    t_round();
    t_sat();
    t_stall();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule